// File: doc/BRIEF.md
# Fetch Address Sequencer

This block holds the program counter of a simple 32-bit load/store processor and works out the next fetch address from the instruction being presented. It chooses one of four sources for the next address. The sequential source is the current address plus 4. The PC-relative branch adds a signed word offset to PC+4 when the branch condition holds. The region jump keeps the top four bits of PC+4 and takes the rest of the address from a 26-bit word index in the instruction. The register jump takes the address from a register value that the datapath supplies.

Instruction memory, the register file and the comparator sit outside the block. Their results reach it only as ports. The block decodes the jump, call, return and branch opcodes itself. For a call it also requests a write of the return address into the link register, in the same cycle that the call is presented.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous active-high reset sets the current address to 0x00000000 at the next rising edge, whatever the advance enable is doing.
- R2: While the advance enable is low, the current address holds its value. While it is high and reset is low, the current address takes the value that next-address showed before the edge.
- R3: If no branch or jump is taken, next-address equals the current address plus 4, computed modulo 2^32.
- R4: Opcode 4 in bits 31:26 is a branch taken when the equality input is high. Opcode 5 is a branch taken when that input is low. An untaken branch follows R3.
- R5: A taken branch goes to PC+4 plus the 16-bit field in bits 15:0, sign-extended and multiplied by 4. Negative offsets move the address backwards.
- R6: Opcode 2 is a jump and opcode 3 is a call. Both go to {PC+4[31:28], bits 25:0, 2'b00}. For example, a field of 2500 gives byte address 10000 within the region.
- R7: The four region bits of a jump or call target come from PC+4, not from the current address. A jump placed in the last word of a 256 MiB region lands in the next region.
- R8: While a call (opcode 3) is presented and the advance enable is high, link-write is high, the link index is 31 and link-data equals the current address plus 4.
- R9: Link-write is low for every non-call opcode, and also for a call while the advance enable is low.
- R10: Opcode 0 with function code 0x08 in bits 5:0 goes to the register-source input, without any alignment change.
- R11: Opcode 0 with any other function code, and every opcode not listed above, takes the sequential path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_en | input | 1 | Allows the current address to advance |
| instr | input | 32 | Instruction word at the current address |
| reg_src | input | 32 | Register value for register jumps |
| eq_flag | input | 1 | High when the two compared registers are equal |
| pc_q | output | 32 | Current fetch address |
| pc_next | output | 32 | Address that will be loaded on the next advance |
| link_we | output | 1 | Request to write the link register |
| link_idx | output | 5 | Link register index, fixed at 31 |
| link_data | output | 32 | Return address to be written |

## Verification
The bench aims at the edges of the address arithmetic. A backward branch catches a design that zero-extends the offset, because that design would jump forward. A jump from the last word of a region catches a design that takes the region bits from the current address, because that design stays in the old region. A branch with the wrong sense of the equality input takes the sequential path when it should branch, and the bench sees this as a wrong next address. A call with the advance enable low, and register-format words with other function codes, expose stray link writes or stray register jumps. Holding the advance enable low shows whether the address creeps forward during a stall.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  localparam int WORD_W  = 32;
  localparam int OPC_W   = 6;
  localparam int FN_W    = 6;
  localparam int IDX_W   = 26;
  localparam int IMM_W   = 16;
  localparam int REGION_W = 4;

  localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'd0;
  localparam logic [OPC_W-1:0] OPC_JUMP    = 6'd2;
  localparam logic [OPC_W-1:0] OPC_CALL    = 6'd3;
  localparam logic [OPC_W-1:0] OPC_BR_EQ   = 6'd4;
  localparam logic [OPC_W-1:0] OPC_BR_NE   = 6'd5;
  localparam logic [FN_W-1:0]  FN_REG_JMP  = 6'h08;

  typedef enum logic [1:0] {
    PATH_SEQ    = 2'd0,
    PATH_BRANCH = 2'd1,
    PATH_REGION = 2'd2,
    PATH_REG    = 2'd3
  } path_e;

  function automatic logic [WORD_W-1:0] seq_addr(input logic [WORD_W-1:0] pc);
    return pc + WORD_W'(4);
  endfunction

  function automatic logic [WORD_W-1:0] branch_addr(input logic [WORD_W-1:0] pc4,
                                                    input logic [IMM_W-1:0]  imm);
    logic [WORD_W-1:0] ofs;
    ofs = {{(WORD_W-IMM_W-2){imm[IMM_W-1]}}, imm, 2'b00};
    return pc4 + ofs;
  endfunction

  function automatic logic [WORD_W-1:0] region_addr(input logic [WORD_W-1:0] pc4,
                                                    input logic [IDX_W-1:0]  idx);
    return {pc4[WORD_W-1 -: REGION_W], idx, 2'b00};
  endfunction
endpackage

// File: rtl/pc_seq_decode.sv
module pc_seq_decode
  import pc_seq_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  input  logic             eq_flag,
  output path_e            path_sel,
  output logic             is_call,
  output logic             is_branch,
  output logic             br_taken
);
  always_comb begin
    path_sel  = PATH_SEQ;
    is_call   = 1'b0;
    is_branch = 1'b0;
    br_taken  = 1'b0;
    unique case (opcode)
      OPC_JUMP: path_sel = PATH_REGION;
      OPC_CALL: begin
        path_sel = PATH_REGION;
        is_call  = 1'b1;
      end
      OPC_BR_EQ: begin
        is_branch = 1'b1;
        br_taken  = eq_flag;
      end
      OPC_BR_NE: begin
        is_branch = 1'b1;
        br_taken  = ~eq_flag;
      end
      OPC_SPECIAL: begin
        if (funct == FN_REG_JMP) path_sel = PATH_REG;
      end
      default: path_sel = PATH_SEQ;
    endcase
    if (br_taken) path_sel = PATH_BRANCH;
  end
endmodule

// File: rtl/pc_seq_target.sv
module pc_seq_target
  import pc_seq_pkg::*;
(
  input  logic [WORD_W-1:0] pc,
  input  logic [IDX_W-1:0]  field,
  input  logic [WORD_W-1:0] reg_src,
  input  path_e             path_sel,
  output logic [WORD_W-1:0] pc_plus4,
  output logic [WORD_W-1:0] pc_next
);
  logic [WORD_W-1:0] br_tgt;
  logic [WORD_W-1:0] rg_tgt;

  assign pc_plus4 = seq_addr(pc);
  assign br_tgt   = branch_addr(pc_plus4, field[IMM_W-1:0]);
  assign rg_tgt   = region_addr(pc_plus4, field);

  always_comb begin
    unique case (path_sel)
      PATH_BRANCH: pc_next = br_tgt;
      PATH_REGION: pc_next = rg_tgt;
      PATH_REG:    pc_next = reg_src;
      default:     pc_next = pc_plus4;
    endcase
  end
endmodule

// File: rtl/pc_seq_reg.sv
module pc_seq_reg #(
  parameter int          W        = 32,
  parameter logic [W-1:0] RESET_PC = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= RESET_PC;
    else if (adv_en) q <= d;
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pc_seq_pkg::*;
#(
  parameter int          NUM_REGS = 32,
  parameter int          LINK_REG = 31,
  parameter logic [31:0] RESET_PC = 32'h0000_0000,
  localparam int         RIDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_en,
  input  logic [31:0]       instr,
  input  logic [31:0]       reg_src,
  input  logic              eq_flag,
  output logic [31:0]       pc_q,
  output logic [31:0]       pc_next,
  output logic              link_we,
  output logic [RIDX_W-1:0] link_idx,
  output logic [31:0]       link_data
);
  path_e             path_sel;
  logic              is_call;
  logic              is_branch;
  logic              br_taken;
  logic [WORD_W-1:0] pc_plus4;

  pc_seq_decode u_dec (
    .opcode    (instr[WORD_W-1 -: OPC_W]),
    .funct     (instr[FN_W-1:0]),
    .eq_flag   (eq_flag),
    .path_sel  (path_sel),
    .is_call   (is_call),
    .is_branch (is_branch),
    .br_taken  (br_taken)
  );

  pc_seq_target u_tgt (
    .pc       (pc_q),
    .field    (instr[IDX_W-1:0]),
    .reg_src  (reg_src),
    .path_sel (path_sel),
    .pc_plus4 (pc_plus4),
    .pc_next  (pc_next)
  );

  pc_seq_reg #(.W(WORD_W), .RESET_PC(RESET_PC)) u_pc (
    .clk    (clk),
    .rst    (rst),
    .adv_en (adv_en),
    .d      (pc_next),
    .q      (pc_q)
  );

  assign link_we   = is_call & adv_en;
  assign link_idx  = RIDX_W'(LINK_REG);
  assign link_data = pc_plus4;

  AST_RESET_LOADS: assert property (@(posedge clk) rst |=> pc_q == RESET_PC); // R1
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !adv_en |=> $stable(pc_q)); // R2
  AST_ADVANCE_LOADS: assert property (@(posedge clk) disable iff (rst)
    adv_en |=> pc_q == $past(pc_next)); // R2
  AST_UNTAKEN_SEQ: assert property (@(posedge clk) disable iff (rst)
    (is_branch && !br_taken) |-> pc_next == pc_q + 32'd4); // R4
  AST_REGION_KEPT: assert property (@(posedge clk) disable iff (rst)
    (path_sel == PATH_REGION) |-> (pc_next[31:28] == pc_plus4[31:28] && pc_next[1:0] == 2'b00)); // R7
  AST_LINK_ADDR: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (link_data == pc_q + 32'd4 && path_sel == PATH_REGION)); // R8
endmodule

// File: tb/pc_sequencer_tb_top.sv
module pc_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        adv_en;
  logic [31:0] instr;
  logic [31:0] reg_src;
  logic        eq_flag;
  logic [31:0] pc_q;
  logic [31:0] pc_next;
  logic        link_we;
  logic [4:0]  link_idx;
  logic [31:0] link_data;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [31:0] model_pc;

  always #5 clk = ~clk;

  pc_sequencer dut_i (
    .clk(clk), .rst(rst), .adv_en(adv_en), .instr(instr), .reg_src(reg_src),
    .eq_flag(eq_flag), .pc_q(pc_q), .pc_next(pc_next), .link_we(link_we),
    .link_idx(link_idx), .link_data(link_data)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_jump(input int op, input int field);
    return (32'(op) << 26) | (32'(field) & 32'h03FF_FFFF);
  endfunction

  function automatic logic [31:0] mk_branch(input int op, input int ofs);
    return (32'(op) << 26) | (32'(ofs) & 32'h0000_FFFF);
  endfunction

  function automatic logic [31:0] mk_special(input int fn);
    return (32'd9 << 21) | (32'(fn) & 32'h3F);
  endfunction

  function automatic logic [31:0] ref_next(input logic [31:0] pc, input logic [31:0] ins,
                                           input logic [31:0] src, input logic eq);
    int unsigned op;
    int off;
    logic [31:0] seq;
    op  = ins >> 26;
    seq = pc + 32'd4;
    off = int'($signed(ins[15:0]));
    case (op)
      2, 3: return (seq & 32'hF000_0000) | ((ins & 32'h03FF_FFFF) * 4);
      4: return eq ? seq + 32'(off * 4) : seq;
      5: return eq ? seq : seq + 32'(off * 4);
      0: return ((ins & 32'h3F) == 32'h8) ? src : seq;
      default: return seq;
    endcase
  endfunction

  task automatic step(input string req, input logic [31:0] ins, input logic [31:0] src,
                      input logic eq, input logic adv);
    logic [31:0] exp_next;
    bit call;
    @(negedge clk);
    instr = ins; reg_src = src; eq_flag = eq; adv_en = adv; rst = 1'b0;
    #1;
    exp_next = ref_next(model_pc, ins, src, eq);
    call = ((ins >> 26) == 3) && adv;
    check(req, "pc_next", pc_next, exp_next);
    check(call ? "R8" : "R9", "link_we", 32'(link_we), 32'(call));
    if (call) begin
      check("R8", "link_idx", 32'(link_idx), 32'd31);
      check("R8", "link_data", link_data, model_pc + 32'd4);
    end
    @(posedge clk);
    if (adv) model_pc = exp_next;
    #1;
    check(adv ? req : "R2", "pc_q", pc_q, model_pc);
  endtask

  task automatic do_reset(input logic adv);
    @(negedge clk);
    rst = 1'b1; adv_en = adv; instr = mk_jump(2, 99); reg_src = '0; eq_flag = 1'b0;
    @(posedge clk);
    model_pc = 32'h0;
    #1;
    check("R1", "pc_q after reset", pc_q, 32'h0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_pc = '0;
    rst = 1'b1; adv_en = 1'b0; instr = '0; reg_src = '0; eq_flag = 1'b0;
    do_reset(1'b0);
    do_reset(1'b1);
    // R3 / R11: sequential flow for other opcodes
    step("R3",  32'h8C00_0000, 32'h0, 1'b0, 1'b1);
    step("R11", 32'h2000_0001, 32'h0, 1'b1, 1'b1);
    // R2: stall holds even with a jump and a call presented
    step("R2", mk_jump(2, 100), 32'h0, 1'b0, 1'b0);
    step("R9", mk_jump(3, 100), 32'h0, 1'b0, 1'b0);
    // R4 / R5 branches
    step("R4", mk_branch(4, 3), 32'h0, 1'b1, 1'b1);
    step("R4", mk_branch(4, 3), 32'h0, 1'b0, 1'b1);
    step("R4", mk_branch(5, 2), 32'h0, 1'b0, 1'b1);
    step("R4", mk_branch(5, 2), 32'h0, 1'b1, 1'b1);
    step("R5", mk_branch(4, -5), 32'h0, 1'b1, 1'b1);
    step("R5", mk_branch(5, -1), 32'h0, 1'b0, 1'b1);
    // R6 jump, field 2500
    step("R6", mk_jump(2, 2500), 32'h0, 1'b0, 1'b1);
    // R8 call
    step("R8", mk_jump(3, 40), 32'h0, 1'b0, 1'b1);
    // R10 register jump, then R7 region boundary
    step("R10", mk_special(8), 32'h0FFF_FFFC, 1'b0, 1'b1);
    step("R7", mk_jump(2, 16), 32'h0, 1'b0, 1'b1);
    step("R10", mk_special(8), 32'h0FFF_FFFC, 1'b0, 1'b1);
    step("R7", mk_jump(3, 5), 32'h0, 1'b0, 1'b1);
    step("R10", mk_special(8), 32'h1234_5677, 1'b0, 1'b1);
    // R11 other function codes under opcode 0
    step("R11", mk_special(32), 32'hDEAD_BEE0, 1'b0, 1'b1);
    step("R11", mk_special(9), 32'hDEAD_BEE0, 1'b0, 1'b1);
    // R3 wrap at top of address space
    step("R10", mk_special(8), 32'hFFFF_FFFC, 1'b0, 1'b1);
    step("R3", 32'hAC00_0000, 32'h0, 1'b0, 1'b1);
    // R1 reset mid-run wins over advance
    step("R3", 32'h8C00_0000, 32'h0, 1'b0, 1'b1);
    do_reset(1'b1);
    step("R3", 32'h8C00_0000, 32'h0, 1'b0, 1'b1);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule